// File: doc/BRIEF.md
# Variable-Rate DAC Slot Request Generator

This block makes one decision per audio link frame: does the codec ask the controller for a new stereo DAC sample in the next frame? When variable-rate mode is off, it asks in every frame, so the DAC sample rate equals the 48 kHz frame rate. When variable-rate mode is on, a programmed rate in Hz sets how often it asks. The requests follow a fixed pattern, so the same rate always gives the same spacing between requests. Both DAC channels share one request flag and one rate.

The decision is driven out as an active-low flag, `slot_req_n`, for the serializer to place in the outgoing input frame. Left and right samples that the controller sends in the output frame after that input frame are kept only if the flag asked for them. `dac_take` marks the frame in which such data may pass to the DAC. Samples in any other frame are dropped.

Top module: `vrate_slot_req`

## Requirements
- R1: With `vra_en` low, every frame tick leaves `slot_req_n` at 0, which means a request.
- R2: With `vra_en` high and an effective rate R, frames are counted n = 1, 2, … from the last restart. Frame n carries a request exactly when floor(n·R/48000) > floor((n−1)·R/48000).
- R3: A rate of 8000 gives a request in every sixth frame. A rate of 9600 gives one in every fifth frame.
- R4: At 8800, requests are spaced 5 or 6 frames apart. The pattern repeats every 60 frames, with 11 requests in each repetition.
- R5: Rate values below 4000 act as 4000, which gives a request every 12th frame. Values above 48000 act as 48000, which gives a request in every frame.
- R6: A change of the effective rate, or a rising edge of `vra_en`, restarts the frame count of R2. The next frame tick is then frame 1.
- R7: After reset, `slot_req_n` is 1 and `dac_take` is 0. The two outputs change only in the cycle after a `frame_tick`.
- R8: After a frame tick, `dac_take` is 1 exactly when the frame that just ended carried a request (`slot_req_n` = 0). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| vra_en | input | 1 | Variable-rate mode enable |
| rate_hz | input | 16 | Programmed DAC sample rate in Hz |
| slot_req_n | output | 1 | Active-low request flag for the current input frame |
| dac_take | output | 1 | High while output-frame DAC data may be accepted |

## Verification
The assertions assume that `frame_tick` is a single-cycle pulse and that reset is held for at least one clock. They also assume that `rate_hz` and `vra_en` may change on any cycle, including a tick cycle. The stimulus keeps `frame_tick` high for exactly one cycle, with idle cycles between ticks. It changes the rate or the mode only in cycles without a tick, so the restart always lands before the next frame decision.

// File: rtl/vrs_pkg.sv
package vrs_pkg;

    localparam int unsigned DEF_FRAME_HZ = 48000;
    localparam int unsigned DEF_MIN_HZ   = 4000;
    localparam int unsigned DEF_RATE_W   = 16;

    typedef struct packed {
        logic req_n;
        logic take;
    } slot_flags_t;

    function automatic logic [31:0] clamp_hz(input logic [31:0] v,
                                             input logic [31:0] lo,
                                             input logic [31:0] hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/vrs_rate_guard.sv
module vrs_rate_guard #(
    parameter int unsigned RATE_W = 16,
    parameter int unsigned MIN_HZ = 4000,
    parameter int unsigned MAX_HZ = 48000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vra_en,
    input  logic [RATE_W-1:0] rate_in,
    output logic [RATE_W-1:0] rate_eff,
    output logic              restart
);
    import vrs_pkg::*;

    logic [RATE_W-1:0] last_rate;
    logic              last_vra;
    logic [31:0]       clamped;

    always_comb begin
        clamped  = clamp_hz(32'(rate_in), 32'(MIN_HZ), 32'(MAX_HZ));
        rate_eff = clamped[RATE_W-1:0];
        restart  = (rate_eff != last_rate) || (vra_en && !last_vra);
    end

    // Tracked during reset too, so stable inputs never cause a restart.
    always_ff @(posedge clk) begin
        last_rate <= rate_eff;
        last_vra  <= vra_en;
    end

    p_stable_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(rate_in) && $stable(vra_en)) |-> !restart);

    p_in_range_r5: assert property (@(posedge clk) disable iff (rst)
        (32'(rate_eff) >= MIN_HZ) && (32'(rate_eff) <= MAX_HZ));

endmodule

// File: rtl/vrs_accum.sv
module vrs_accum #(
    parameter int unsigned FRAME_HZ = 48000,
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned ACC_W    = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              vra_en,
    input  logic              restart,
    input  logic [RATE_W-1:0] rate_eff,
    output logic              hit
);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(FRAME_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] sum;

    always_comb begin
        base = restart ? '0 : acc_q;
        sum  = base + ACC_W'(rate_eff);
        hit  = !vra_en || (sum >= LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst || !vra_en) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= (sum >= LIMIT) ? sum - LIMIT : sum;
        end else if (restart) begin
            acc_q <= '0;
        end
    end

    p_acc_bound_r2: assert property (@(posedge clk) disable iff (rst)
        acc_q < LIMIT);

    p_restart_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (restart && !tick) |=> (acc_q == '0));

endmodule

// File: rtl/vrs_flags.sv
module vrs_flags (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 hit,
    output vrs_pkg::slot_flags_t flags
);
    import vrs_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags.req_n <= 1'b1;
            flags.take  <= 1'b0;
        end else if (tick) begin
            flags.take  <= !flags.req_n;
            flags.req_n <= !hit;
        end
    end

    p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(flags));

    p_take_after_request_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.take) |-> ($past(tick) && !$past(flags.req_n)));

endmodule

// File: rtl/vrate_slot_req.sv
module vrate_slot_req #(
    parameter int unsigned FRAME_HZ = vrs_pkg::DEF_FRAME_HZ,
    parameter int unsigned MIN_HZ   = vrs_pkg::DEF_MIN_HZ,
    parameter int unsigned RATE_W   = vrs_pkg::DEF_RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_tick,
    input  logic              vra_en,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              slot_req_n,
    output logic              dac_take
);
    import vrs_pkg::*;

    localparam int unsigned ACC_W = $clog2(2 * FRAME_HZ);

    logic [RATE_W-1:0] rate_eff;
    logic              restart;
    logic              hit;
    slot_flags_t       flags;

    vrs_rate_guard #(.RATE_W(RATE_W), .MIN_HZ(MIN_HZ), .MAX_HZ(FRAME_HZ)) u_guard (
        .clk(clk), .rst(rst), .vra_en(vra_en), .rate_in(rate_hz),
        .rate_eff(rate_eff), .restart(restart)
    );

    vrs_accum #(.FRAME_HZ(FRAME_HZ), .RATE_W(RATE_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst(rst), .tick(frame_tick), .vra_en(vra_en),
        .restart(restart), .rate_eff(rate_eff), .hit(hit)
    );

    vrs_flags u_flags (
        .clk(clk), .rst(rst), .tick(frame_tick), .hit(hit), .flags(flags)
    );

    assign slot_req_n = flags.req_n;
    assign dac_take   = flags.take;

    p_fixed_rate_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_tick && !vra_en) |=> !slot_req_n);

    p_reset_state_r7: assert property (@(posedge clk)
        rst |=> (slot_req_n && !dac_take));

endmodule

// File: tb/vrate_slot_req_test.sv
module vrate_slot_req_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_tick = 1'b0;
    logic        vra_en = 1'b0;
    logic [15:0] rate_hz = 16'd48000;
    logic        slot_req_n;
    logic        dac_take;

    int total = 0;
    int bad   = 0;
    int n_frame = 0;
    bit prev_req = 1'b0;
    int cur_rate = 48000;
    bit cur_vra = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vrate_slot_req uut (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .vra_en(vra_en),
        .rate_hz(rate_hz), .slot_req_n(slot_req_n), .dac_take(dac_take)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic bit ideal(input int n, input int r);
        longint a = (longint'(n) * r) / 48000;
        longint b = (longint'(n - 1) * r) / 48000;
        return a > b;
    endfunction

    function automatic int eff(input int r);
        if (r < 4000) return 4000;
        if (r > 48000) return 48000;
        return r;
    endfunction

    // One frame: pulse the tick, check both outputs, then check that they hold.
    task automatic frame(input string rq, output bit got_req);
        bit exp_req;
        bit s_req, s_take;
        n_frame++;
        exp_req = cur_vra ? ideal(n_frame, eff(cur_rate)) : 1'b1;
        @(negedge clk) frame_tick = 1'b1;
        @(negedge clk) frame_tick = 1'b0;
        check(slot_req_n == !exp_req, rq, slot_req_n, !exp_req);
        check(dac_take == prev_req, "R8", dac_take, prev_req);
        s_req = slot_req_n; s_take = dac_take;
        @(negedge clk);
        @(negedge clk);
        check(slot_req_n == s_req && dac_take == s_take, "R7", {slot_req_n, dac_take}, {s_req, s_take});
        prev_req = exp_req;
        got_req = !slot_req_n;
    endtask

    task automatic set_mode(input bit v, input int r);
        @(negedge clk);
        vra_en = v; rate_hz = 16'(r);
        cur_vra = v; cur_rate = r;
        @(negedge clk);
        n_frame = 0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(slot_req_n == 1'b1, "R7", slot_req_n, 1);
        check(dac_take == 1'b0, "R7", dac_take, 0);
        rst = 1'b0;
    endtask

    task automatic t_fixed();
        bit g;
        for (int i = 0; i < 4; i++) frame("R1", g);
    endtask

    task automatic t_period(input int r, input int per, input string rq);
        bit g;
        set_mode(1'b1, r);
        for (int i = 1; i <= 3 * per; i++) begin
            frame(rq, g);
            check(g == (i % per == 0), rq, g, i % per == 0);
        end
        set_mode(1'b0, r);
    endtask

    task automatic t_8800();
        bit g;
        int last = 0;
        int cnt = 0;
        set_mode(1'b1, 8800);
        for (int i = 1; i <= 120; i++) begin
            frame("R4", g);
            if (g) begin
                if (last != 0) check((i - last == 5) || (i - last == 6), "R4", i - last, 5);
                last = i;
                if (i <= 60) cnt++;
            end
        end
        check(cnt == 11, "R4", cnt, 11);
        check(last == 120, "R4", last, 120);
        set_mode(1'b0, 8800);
    endtask

    task automatic t_restart();
        bit g;
        set_mode(1'b1, 8000);
        for (int i = 0; i < 3; i++) frame("R6", g);
        set_mode(1'b1, 9600);
        for (int i = 1; i <= 5; i++) begin
            frame("R6", g);
            check(g == (i == 5), "R6", g, i == 5);
        end
        for (int i = 0; i < 2; i++) frame("R6", g);
        set_mode(1'b0, 9600);
        frame("R1", g);
        set_mode(1'b1, 9600);
        for (int i = 1; i <= 5; i++) begin
            frame("R6", g);
            check(g == (i == 5), "R6", g, i == 5);
        end
        set_mode(1'b0, 9600);
    endtask

    task automatic t_general(input int r);
        bit g;
        set_mode(1'b1, r);
        for (int i = 0; i < 30; i++) frame("R2", g);
        set_mode(1'b0, r);
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed();
        t_period(8000, 6, "R3");
        t_period(9600, 5, "R3");
        t_8800();
        t_period(0, 12, "R5");
        t_period(1000, 12, "R5");
        t_period(60000, 1, "R5");
        t_period(48000, 1, "R2");
        t_restart();
        t_general(44100);
        t_general(11025);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule